// File: doc/BRIEF.md
# Parallel-ATA PIO Register Cycle Sequencer

This block sits on the host side of a parallel ATA-style disk bus and runs one register read or one register write per request in any of the five PIO timing modes. The host presents a register address, a direction, write data and a mode number together with a one-cycle request. The block then sequences the address setup phase, the active-low command strobe and the recovery phase, and it controls the output enable of the host data drivers. At the end it raises a one-cycle done pulse and, for reads, presents the captured data.

Every phase length is a whole number of system clocks. The counts come from per-mode minimum times in nanoseconds, rounded up at the configured clock period, and are selected from the mode input when a request is accepted. The device can stretch the command phase by holding its ready line low. The block samples that line once at a fixed delay after the strobe falls. If ready is low at that point, the strobe is held until ready returns high. A wait that lasts too long ends the transfer with an error flag.

Top module: `ata_pio_regseq`

## Requirements
- R1: While reset is held and right after it is released, both strobes are high (inactive), the output enable is low, and busy, done and err are low.
- R2: At a 10 ns clock, the address is driven with both strobes high for exactly 7, 5, 3, 3 and 3 clocks (modes 0 to 4) before a strobe falls. A strobe is only low while busy is high.
- R3: Throughout a transfer the bus address, and for writes the driven data, stay at the values latched when the request was accepted, even if the host inputs change.
- R4: If ready is high at the sample point, the strobe stays low for exactly 29, 29, 29, 8 and 7 clocks in modes 0 to 4.
- R5: After the strobe rises, the block waits 24, 5, 3, 7 and 3 recovery clocks in modes 0 to 4 and then pulses done. Setup plus strobe plus recovery is at least the rounded cycle minimum of 60, 39, 24, 18 and 12 clocks.
- R6: Ready is sampled at the 4th rising edge after the strobe falls. If it is low there, the strobe rises at the first edge that sees ready high, whether that is earlier or later than the R4 width.
- R7: If ready is still low 125 edges after the sample point, the strobe rises at that edge, done and err pulse together in the next cycle with busy low, no recovery phase runs, and the next request runs normally.
- R8: A read (wr=0) drives only rd_n low, keeps the output enable low, and returns in rdata the value on din at the edge where rd_n is released.
- R9: A write (wr=1) drives only wr_n low, and the output enable is high from the first busy cycle until the end of recovery, so it covers at least one clock after wr_n rises.
- R10: Mode codes 5, 6 and 7 use the mode-4 timing.
- R11: done is a single-cycle pulse with busy low. A request raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 ns period by default) |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a transfer (sampled while idle) |
| wr | input | 1 | 1 = register write, 0 = register read |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| mode | input | 3 | PIO timing mode, 0 to 4 (higher codes act as 4) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Ready wait timed out (valid with done) |
| rdata | output | 16 | Captured read data |
| ata_addr | output | 3 | Address lines to the device |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| dout | output | 16 | Data driven toward the device |
| dout_oe | output | 1 | Output enable for dout |
| din | input | 16 | Data from the device |
| rdy | input | 1 | Device ready (low = stretch) |

## Verification
The assertions check the cycle-level invariants on every clock: the two strobes are never low together, the output enable never overlaps a read strobe and always covers a write strobe and the clock after it, the address and write data stay stable within a transfer, done is a lone pulse, err only appears with done, and no strobe stays low longer than the sample delay plus the wait limit. The phase lengths for each mode, the choice between minimum width and ready release, the exact timeout edge, the captured read value and the mode clamping are all relative to the mode and the device's behaviour. Only the bench's scenarios can show those, because it counts clocks per phase against its own table of nanosecond minimums.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_CMD   = 2'd2,
        PH_RECOV = 2'd3
    } phase_e;

    // Clock counts for one mode
    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } tmg_t;

    function automatic int clk_ceil(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Minimum full cycle per mode, ns
    function automatic int cycle_min_ns(input int m);
        case (m)
            0:       return 600;
            1:       return 383;
            2:       return 240;
            3:       return 180;
            default: return 120;
        endcase
    endfunction

    // Minimum address-to-strobe setup per mode, ns
    function automatic int setup_min_ns(input int m);
        case (m)
            0:       return 70;
            1:       return 50;
            2, 3:    return 30;
            default: return 25;
        endcase
    endfunction

    // Minimum strobe-low width per mode (8-bit register access), ns
    function automatic int strobe_min_ns(input int m);
        case (m)
            0, 1, 2: return 290;
            3:       return 80;
            default: return 70;
        endcase
    endfunction

endpackage

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
    import ata_pio_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int TURN_NS   = 30,
    parameter int MODE_W    = 3,
    parameter int NUM_MODES = 5
) (
    input  logic [MODE_W-1:0] mode,
    output tmg_t              tmg
);

    localparam logic [MODE_W-1:0] TOP_MODE = MODE_W'(NUM_MODES - 1);
    localparam int TURN_CLK = clk_ceil(TURN_NS, CLK_NS);

    tmg_t              tbl [NUM_MODES];
    logic [MODE_W-1:0] sel;

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        localparam int S_CLK = clk_ceil(setup_min_ns(g), CLK_NS);
        localparam int A_CLK = clk_ceil(strobe_min_ns(g), CLK_NS);
        localparam int C_CLK = clk_ceil(cycle_min_ns(g), CLK_NS);
        // Recovery stretched so setup+active+recovery meets the cycle minimum
        localparam int R_RAW = C_CLK - S_CLK - A_CLK;
        localparam int R_CLK = (R_RAW > TURN_CLK) ? R_RAW : TURN_CLK;
        assign tbl[g] = '{setup:  CNT_W'(S_CLK),
                          active: CNT_W'(A_CLK),
                          recov:  CNT_W'(R_CLK)};
    end

    always_comb begin
        sel = (mode > TOP_MODE) ? TOP_MODE : mode;
        tmg = tbl[sel];
    end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int SMP    = 4,
    parameter int TMO    = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  tmg_t              tmg_i,
    input  logic [DATA_W-1:0] din,
    input  logic              rdy,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    localparam int WAIT_W = $clog2(TMO + 1);
    localparam logic [CNT_W-1:0]  SMP_LAST = CNT_W'(SMP - 1);
    localparam logic [WAIT_W-1:0] TMO_LAST = WAIT_W'(TMO - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  tmr;
        logic [WAIT_W-1:0] wcnt;
        logic              waiting;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        tmg_t              tmg;
        logic              done;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;
    logic cmd_end;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        cmd_end  = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (req) begin
                    s_d.phase   = PH_SETUP;
                    s_d.tmr     = '0;
                    s_d.wcnt    = '0;
                    s_d.waiting = 1'b0;
                    s_d.is_wr   = wr;
                    s_d.addr    = addr;
                    s_d.wdata   = wdata;
                    s_d.tmg     = tmg_i;
                end
            end
            PH_SETUP: begin
                if (s_q.tmr == s_q.tmg.setup - 1'b1) begin
                    s_d.phase = PH_CMD;
                    s_d.tmr   = '0;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
            end
            PH_CMD: begin
                if (s_q.tmr != '1) begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
                if (s_q.waiting) begin
                    // Device stretch: ready release ends the strobe
                    if (rdy) begin
                        cmd_end = 1'b1;
                    end else if (s_q.wcnt == TMO_LAST) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                        s_d.err   = 1'b1;
                    end else begin
                        s_d.wcnt = s_q.wcnt + 1'b1;
                    end
                end else if (s_q.tmr == SMP_LAST && !rdy) begin
                    s_d.waiting = 1'b1;
                end else if (s_q.tmr >= s_q.tmg.active - 1'b1) begin
                    cmd_end = 1'b1;
                end
                if (cmd_end) begin
                    s_d.phase = PH_RECOV;
                    s_d.tmr   = '0;
                    if (!s_q.is_wr) begin
                        s_d.rdata = din;
                    end
                end
            end
            PH_RECOV: begin
                if (s_q.tmr == s_q.tmg.recov - 1'b1) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.phase != PH_IDLE);
    assign done     = s_q.done;
    assign err      = s_q.err;
    assign rdata    = s_q.rdata;
    assign ata_addr = s_q.addr;
    assign rd_n     = !((s_q.phase == PH_CMD) && !s_q.is_wr);
    assign wr_n     = !((s_q.phase == PH_CMD) && s_q.is_wr);
    assign dout     = s_q.wdata;
    assign dout_oe  = busy && s_q.is_wr;

endmodule

// File: rtl/ata_pio_regseq.sv
module ata_pio_regseq
    import ata_pio_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 16,
    parameter int MODE_W     = 3,
    parameter int RDY_SMP_NS = 35,
    parameter int RDY_MAX_NS = 1250,
    parameter int TURN_NS    = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MODE_W-1:0] mode,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic [DATA_W-1:0] din,
    input  logic              rdy
);

    localparam int SMP = clk_ceil(RDY_SMP_NS, CLK_NS);
    localparam int TMO = clk_ceil(RDY_MAX_NS, CLK_NS);

    tmg_t tmg;

    ata_pio_timing #(
        .CLK_NS    (CLK_NS),
        .TURN_NS   (TURN_NS),
        .MODE_W    (MODE_W),
        .NUM_MODES (5)
    ) u_timing (
        .mode (mode),
        .tmg  (tmg)
    );

    ata_pio_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SMP    (SMP),
        .TMO    (TMO)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .wr       (wr),
        .addr     (addr),
        .wdata    (wdata),
        .tmg_i    (tmg),
        .din      (din),
        .rdy      (rdy),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .rdata    (rdata),
        .ata_addr (ata_addr),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

endmodule

// File: rtl/ata_pio_regseq_chk.sv
module ata_pio_regseq_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int SMP    = 4,
    parameter int TMO    = 125
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] ata_addr,
    input logic              rd_n,
    input logic              wr_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe
);

    localparam int LIMIT = SMP + TMO;
    localparam int RUN_W = $clog2(LIMIT + 2);

    logic [RUN_W-1:0] low_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (!rd_n || !wr_n) begin
            if (low_run_q != '1) begin
                low_run_q <= low_run_q + 1'b1;
            end
        end else begin
            low_run_q <= '0;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R9
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> busy); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R7
    AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ata_addr) && (!dout_oe || $stable(dout)))); // R3
    AST_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> dout_oe); // R9
    AST_OE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_n) && !done) |-> dout_oe); // R9
    AST_NO_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !dout_oe); // R8
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= RUN_W'(LIMIT)); // R7

endmodule

bind ata_pio_regseq ata_pio_regseq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SMP    (SMP),
    .TMO    (TMO)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .ata_addr (ata_addr),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .dout     (dout),
    .dout_oe  (dout_oe)
);

// File: tb/ata_pio_regseq_tb_top.sv
module ata_pio_regseq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [2:0]  mode = '0;
    logic        busy, done, err;
    logic [15:0] rdata;
    logic [2:0]  ata_addr;
    logic        rd_n, wr_n;
    logic [15:0] dout;
    logic        dout_oe;
    logic [15:0] din = 16'hdead;
    logic        rdy = 1'b1;

    int total = 0;
    int bad = 0;
    int hold_cfg = 0;
    logic [15:0] rdval = 16'h0;
    int low_cnt = 0;

    always #5 clk = ~clk;

    ata_pio_regseq dut_i (
        .clk (clk), .rst_n (rst_n), .req (req), .wr (wr), .addr (addr),
        .wdata (wdata), .mode (mode), .busy (busy), .done (done), .err (err),
        .rdata (rdata), .ata_addr (ata_addr), .rd_n (rd_n), .wr_n (wr_n),
        .dout (dout), .dout_oe (dout_oe), .din (din), .rdy (rdy)
    );

    // Device model: ready low for the first hold_cfg strobe clocks
    always @(negedge clk) begin
        if (!rd_n || !wr_n) begin
            low_cnt = low_cnt + 1;
            rdy <= (hold_cfg == 0) || (low_cnt >= hold_cfg);
            din <= rdval;
        end else begin
            low_cnt = 0;
            rdy <= 1'b1;
            din <= 16'hdead;
        end
    end

    // Expected counts from ns minimums at 10 ns (modes above 4 act as 4, R10)
    function automatic int cl(input int ns);
        return (ns + 9) / 10;
    endfunction
    function automatic int mclamp(input int m);
        return (m > 4) ? 4 : m;
    endfunction
    function automatic int e_setup(input int m);
        int t [5] = '{70, 50, 30, 30, 25};
        return cl(t[mclamp(m)]);
    endfunction
    function automatic int e_act(input int m);
        int t [5] = '{290, 290, 290, 80, 70};
        return cl(t[mclamp(m)]);
    endfunction
    function automatic int e_cyc(input int m);
        int t [5] = '{600, 383, 240, 180, 120};
        return cl(t[mclamp(m)]);
    endfunction
    function automatic int e_rec(input int m);
        int r;
        r = e_cyc(m) - e_setup(m) - e_act(m);
        return (r > 3) ? r : 3;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic run_xfer(input int m, input bit w, input int hold,
                            input logic [2:0] a, input logic [15:0] d,
                            output int s_c, output int w_c, output int r_c,
                            output bit e, output logic [15:0] rd, output bit ok);
        bit seen;
        int n;
        s_c = 0; w_c = 0; r_c = 0; ok = 1; seen = 0; n = 0;
        hold_cfg = hold;
        rdval = d;
        @(negedge clk);
        req = 1'b1; wr = w; mode = 3'(m); addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0; addr = ~a; wdata = ~d;
        while (!done && n < 3000) begin
            if (!rd_n || !wr_n) begin
                w_c++;
                seen = 1;
                if (w && (!dout_oe || dout !== d || !rd_n)) ok = 0;
                if (!w && (dout_oe || !wr_n)) ok = 0;
            end else if (busy) begin
                if (seen) begin
                    r_c++;
                    if (r_c == 1 && w && !dout_oe) ok = 0;
                end else begin
                    s_c++;
                end
            end
            if (busy && ata_addr !== a) ok = 0;
            n++;
            @(negedge clk);
        end
        if (!done) ok = 0;
        e = err;
        rd = rdata;
    endtask

    // {mode[3], wr, hold[16], addr[3], data[16]}
    localparam int NV = 10;
    localparam logic [38:0] VECS [NV] = '{
        {3'd0, 1'b0, 16'd0,  3'd1, 16'h1234},
        {3'd1, 1'b1, 16'd0,  3'd2, 16'hA55A},
        {3'd2, 1'b0, 16'd2,  3'd3, 16'h0F0F},
        {3'd3, 1'b1, 16'd0,  3'd4, 16'hBEEF},
        {3'd4, 1'b0, 16'd0,  3'd5, 16'hC001},
        {3'd4, 1'b0, 16'd20, 3'd6, 16'h7E57},
        {3'd0, 1'b1, 16'd12, 3'd7, 16'h4242},
        {3'd3, 1'b0, 16'd60, 3'd0, 16'h9999},
        {3'd6, 1'b1, 16'd0,  3'd1, 16'h3C3C},
        {3'd5, 1'b0, 16'd10, 3'd2, 16'h6006}
    };

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s_c, w_c, r_c;
        bit e, ok;
        logic [15:0] rd;

        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk(rd_n && wr_n && !dout_oe && !busy && !done && !err, "R1",
            {rd_n, wr_n, dout_oe, busy, done, err}, 6'b110000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_n && wr_n && !dout_oe && !busy && !done && !err, "R1 after release",
            {rd_n, wr_n, dout_oe, busy, done, err}, 6'b110000);

        for (int i = 0; i < NV; i++) begin
            int m, hold, exp_w;
            bit w;
            logic [2:0] a;
            logic [15:0] d;
            m = int'(VECS[i][38:36]);
            w = VECS[i][35];
            hold = int'(VECS[i][34:19]);
            a = VECS[i][18:16];
            d = VECS[i][15:0];
            run_xfer(m, w, hold, a, d, s_c, w_c, r_c, e, rd, ok);
            // R6: stretched when ready is low at the 4th edge, else R4 width
            exp_w = (hold > 4) ? hold : e_act(m);
            chk(s_c == e_setup(m), "R2 setup (R10 clamp)", s_c, e_setup(m));
            chk(w_c == exp_w, (hold > 4) ? "R6 ready stretch" : "R4 strobe width", w_c, exp_w);
            chk(r_c == e_rec(m), "R5 recovery", r_c, e_rec(m));
            chk(hold > 4 || (s_c + w_c + r_c) >= e_cyc(m), "R5 cycle min",
                s_c + w_c + r_c, e_cyc(m));
            chk(ok, w ? "R9 write strobe/oe, R3 hold" : "R8 read strobe/oe, R3 hold",
                ok, 1);
            chk(!e, "R7 no error", e, 0);
            if (!w) chk(rd == d, "R8 read data", rd, d);
            @(negedge clk);
            chk(!done && !busy, "R11 done single pulse", {done, busy}, 0);
        end

        // R7: ready held low past the limit
        run_xfer(1, 1'b0, 1000, 3'd5, 16'h5151, s_c, w_c, r_c, e, rd, ok);
        chk(e, "R7 err flag", e, 1);
        chk(w_c == 4 + 125, "R7 timeout edge", w_c, 129);
        chk(r_c == 0, "R7 no recovery", r_c, 0);
        chk(!busy, "R7 idle with done", busy, 0);
        run_xfer(2, 1'b0, 0, 3'd3, 16'h2468, s_c, w_c, r_c, e, rd, ok);
        chk(!e && rd == 16'h2468 && w_c == e_act(2), "R7 recovers after timeout",
            w_c, e_act(2));

        // R11: request while busy is ignored
        hold_cfg = 0;
        rdval = 16'h1111;
        @(negedge clk);
        req = 1'b1; wr = 1'b0; mode = 3'd4; addr = 3'd2;
        @(negedge clk);
        req = 1'b0;
        repeat (4) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 3'd7; mode = 3'd0;
        @(negedge clk);
        @(negedge clk);
        req = 1'b0;
        chk(ata_addr == 3'd2 && wr_n, "R11 busy req ignored (addr)", ata_addr, 2);
        begin
            int n;
            n = 0;
            while (!done && n < 200) begin n++; @(negedge clk); end
        end
        chk(rdata == 16'h1111, "R11 first transfer data", rdata, 16'h1111);
        begin
            int busy_seen;
            busy_seen = 0;
            repeat (10) begin @(negedge clk); if (busy || done) busy_seen++; end
            chk(busy_seen == 0, "R11 no second transfer", busy_seen, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule